// File: doc/BRIEF.md
# Delta-Modulation Sample Fetch Controller

This block keeps a one-byte buffer filled for a delta-modulation output unit. Software programs three 8-bit values through a small write port: a control byte that holds an interrupt enable and a loop flag, an address code and a length code. The block scales the codes into a 16-bit start address and a byte count. When the channel enable input rises with no bytes left, it loads the current address and the byte count. From then on it reads one byte from memory each time the buffer is empty and bytes remain.

Each read is a request held on the memory port until the memory acknowledges it with data. While that request is open, the block asks the processor to stall. The fetched byte lands in the buffer, which is presented to the output unit as a valid/ready stream. The byte stays on `buf_data` with `buf_valid` high until the unit takes it with `buf_ready`. No new fetch starts while the buffer is full, so the output unit's back-pressure is the only thing that paces fetching.

After the last byte the block either reloads the start address and count (loop) or, when looping is off and interrupts are enabled, raises a sticky interrupt.

Top module: `smp_fetch_ctl`

## Requirements
- R1: A write with `wr_sel`=1 stores an address code A; the next loaded start address is 0xC000 + 64*A.
- R2: A write with `wr_sel`=2 stores a length code L; a started sample fetches exactly 16*L + 1 bytes.
- R3: A write with `wr_sel`=0 takes the interrupt enable from `wr_data` bit 7 and the loop flag from bit 6. Bits 5..0 are ignored. Such a write with bit 7 clear drops `irq` the next cycle. `wr_sel`=3 writes nothing.
- R4: When `chan_en` is first sampled high while no bytes remain, the address and count load at that edge, and `mem_req` rises one clock edge later.
- R5: A fetch starts when the buffer is empty, bytes remain and `chan_en` is high. `mem_req` and `mem_addr` then stay stable until a cycle with `mem_ack` high.
- R6: `stall` is high exactly while a fetch is outstanding. In the cycle after the acknowledge, `stall` is low and `buf_valid` is high with the acknowledged byte.
- R7: After each fetched byte the address increments; the increment from 0xFFFF gives 0x8000, so `mem_addr` never drops below 0x8000 during a fetch.
- R8: When the last byte is fetched with loop set, the address and count reload from the start values and fetching goes on without a new enable.
- R9: When the last byte is fetched with loop clear and interrupt enable set, `irq` goes high the next cycle and stays high until cleared as in R3. With loop set, `irq` does not rise.
- R10: While `chan_en` is low the remaining count is zero and no new fetch starts; a fetch already outstanding still completes.
- R11: `buf_valid` and `buf_data` hold while `buf_ready` is low; after a cycle with both high, `buf_valid` is low unless a fetch completes in that cycle.
- R12: After reset `mem_req`, `stall`, `irq` and `buf_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Channel enable; rising starts a sample, low stops it |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 control, 1 address code, 2 length code, 3 none |
| wr_data | input | 8 | Register write value |
| mem_req | output | 1 | Memory read request (valid) |
| mem_addr | output | 16 | Address of the requested byte |
| mem_ack | input | 1 | Memory acknowledge; `mem_data` is valid with it |
| mem_data | input | 8 | Byte returned by memory |
| buf_valid | output | 1 | Buffer holds a byte for the output unit |
| buf_ready | input | 1 | Output unit takes the buffered byte |
| buf_data | output | 8 | Buffered byte |
| stall | output | 1 | Processor-stall request |
| irq | output | 1 | End-of-sample interrupt flag |

## Verification
On every cycle the assertions check the stream rules and the fetch rules. A request holds its address until acknowledged, and no request is open while the buffer is full. An acknowledge fills the buffer and drops the stall. Every fetched address stays in the upper half of memory, an interrupt-disabling control write clears `irq`, and no fetch starts while the channel is disabled. The scenarios in the bench are needed for everything that depends on counting and sequence. These are the scaled start address and byte count, the wrap from 0xFFFF to 0x8000 in the middle of a sample, loop restarts, the single interrupt at the end, and a disable that arrives while a fetch is outstanding.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_LEN  = 2'd2;
  localparam int CTRL_IRQ_BIT  = 7;
  localparam int CTRL_LOOP_BIT = 6;
endpackage

// File: rtl/sfc_regs.sv
module sfc_regs
  import sfc_pkg::*;
#(
  parameter int          CODE_W     = 8,
  parameter int          ADDR_W     = 16,
  parameter logic [15:0] BASE_ADDR  = 16'hC000,
  parameter int          ADDR_SHIFT = 6,
  parameter int          LEN_SHIFT  = 4,
  localparam int         LEN_W      = CODE_W + LEN_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [CODE_W-1:0] wr_data,
  output logic              irq_en,
  output logic              loop_en,
  output logic              irq_clr,
  output logic [ADDR_W-1:0] start_addr,
  output logic [LEN_W-1:0]  sample_len
);
  logic [CODE_W-1:0] addr_code;
  logic [CODE_W-1:0] len_code;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en    <= 1'b0;
      loop_en   <= 1'b0;
      addr_code <= '0;
      len_code  <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_CTRL: begin
          irq_en  <= wr_data[CTRL_IRQ_BIT];
          loop_en <= wr_data[CTRL_LOOP_BIT];
        end
        SEL_ADDR: addr_code <= wr_data;
        SEL_LEN:  len_code  <= wr_data;
        default:  ;
      endcase
    end
  end

  assign irq_clr    = wr_en && (wr_sel == SEL_CTRL) && !wr_data[CTRL_IRQ_BIT];
  assign start_addr = BASE_ADDR[ADDR_W-1:0] + (ADDR_W'(addr_code) << ADDR_SHIFT);
  assign sample_len = (LEN_W'(len_code) << LEN_SHIFT) + LEN_W'(1);
endmodule

// File: rtl/sfc_track.sv
module sfc_track #(
  parameter int          ADDR_W    = 16,
  parameter int          LEN_W     = 12,
  parameter logic [15:0] BASE_ADDR = 16'hC000,
  parameter logic [15:0] WRAP_ADDR = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  sample_len,
  input  logic              loop_en,
  input  logic              irq_en,
  input  logic              irq_clr,
  input  logic              fetch_done,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              remain_nz,
  output logic              irq
);
  logic [LEN_W-1:0]  remain;
  logic              en_q;
  logic              launch;
  logic              last;
  logic [ADDR_W-1:0] addr_inc;

  assign launch    = chan_en && !en_q && (remain == '0);
  assign last      = (remain == LEN_W'(1));
  assign remain_nz = (remain != '0);
  assign addr_inc  = (cur_addr == '1) ? WRAP_ADDR[ADDR_W-1:0] : cur_addr + ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= BASE_ADDR[ADDR_W-1:0];
      remain   <= '0;
      en_q     <= 1'b0;
      irq      <= 1'b0;
    end else begin
      en_q <= chan_en;
      if (fetch_done) cur_addr <= addr_inc;
      if (!chan_en) begin
        remain <= '0;
      end else if (launch) begin
        cur_addr <= start_addr;
        remain   <= sample_len;
      end else if (fetch_done && remain_nz) begin
        if (last && loop_en) begin
          cur_addr <= start_addr;
          remain   <= sample_len;
        end else begin
          remain <= remain - LEN_W'(1);
        end
      end
      if (irq_clr) irq <= 1'b0;
      else if (fetch_done && last && !loop_en && irq_en) irq <= 1'b1;
    end
  end
endmodule

// File: rtl/sfc_fetch.sv
module sfc_fetch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              can_fetch,
  output logic              busy,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_data,
  output logic              buf_full,
  input  logic              buf_ready,
  output logic [DATA_W-1:0] buf_data,
  output logic              fetch_done
);
  assign fetch_done = busy && mem_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      buf_full <= 1'b0;
      buf_data <= '0;
    end else if (fetch_done) begin
      busy     <= 1'b0;
      buf_full <= 1'b1;
      buf_data <= mem_data;
    end else begin
      if (!busy && !buf_full && can_fetch) busy <= 1'b1;
      if (buf_full && buf_ready) buf_full <= 1'b0;
    end
  end
endmodule

// File: rtl/smp_fetch_ctl.sv
module smp_fetch_ctl #(
  parameter int          ADDR_W     = 16,
  parameter int          DATA_W     = 8,
  parameter int          ADDR_SHIFT = 6,
  parameter int          LEN_SHIFT  = 4,
  parameter logic [15:0] BASE_ADDR  = 16'hC000,
  parameter logic [15:0] WRAP_ADDR  = 16'h8000,
  localparam int         LEN_W      = DATA_W + LEN_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_data,
  output logic              buf_valid,
  input  logic              buf_ready,
  output logic [DATA_W-1:0] buf_data,
  output logic              stall,
  output logic              irq
);
  logic              irq_en, loop_en, irq_clr;
  logic [ADDR_W-1:0] start_addr;
  logic [LEN_W-1:0]  sample_len;
  logic              remain_nz, fetch_done, busy;

  sfc_regs #(
    .CODE_W(DATA_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR),
    .ADDR_SHIFT(ADDR_SHIFT), .LEN_SHIFT(LEN_SHIFT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .irq_en(irq_en), .loop_en(loop_en), .irq_clr(irq_clr),
    .start_addr(start_addr), .sample_len(sample_len)
  );

  sfc_track #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BASE_ADDR(BASE_ADDR), .WRAP_ADDR(WRAP_ADDR)
  ) u_track (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
    .start_addr(start_addr), .sample_len(sample_len),
    .loop_en(loop_en), .irq_en(irq_en), .irq_clr(irq_clr),
    .fetch_done(fetch_done), .cur_addr(mem_addr), .remain_nz(remain_nz), .irq(irq)
  );

  sfc_fetch #(.DATA_W(DATA_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .can_fetch(remain_nz && chan_en), .busy(busy),
    .mem_ack(mem_ack), .mem_data(mem_data), .buf_full(buf_valid),
    .buf_ready(buf_ready), .buf_data(buf_data), .fetch_done(fetch_done)
  );

  assign mem_req = busy;
  assign stall   = busy;
endmodule

// File: rtl/smp_fetch_ctl_chk.sv
module smp_fetch_ctl_chk #(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter logic [15:0] WRAP_ADDR = 16'h8000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chan_en,
  input logic              ctl_off_wr,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic              buf_valid,
  input logic              buf_ready,
  input logic [DATA_W-1:0] buf_data,
  input logic              stall,
  input logic              irq
);
  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  // R6
  ack_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> !stall && buf_valid);
  // R11
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid && !buf_ready |=> buf_valid && $stable(buf_data));
  // R11
  no_fetch_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid |-> !mem_req);
  // R7
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr >= WRAP_ADDR[ADDR_W-1:0]);
  // R3
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_off_wr |=> !irq);
  // R10
  disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en && !mem_req |=> !mem_req);
endmodule

bind smp_fetch_ctl smp_fetch_ctl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WRAP_ADDR(WRAP_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
  .ctl_off_wr(wr_en && (wr_sel == 2'd0) && !wr_data[7]),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
  .buf_valid(buf_valid), .buf_ready(buf_ready), .buf_data(buf_data),
  .stall(stall), .irq(irq)
);

// File: tb/sim_smp_fetch_ctl.sv
module sim_smp_fetch_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chan_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd3;
  logic [7:0] wr_data = 8'd0;
  logic       mem_req;
  logic [15:0] mem_addr;
  logic       mem_ack = 1'b0;
  logic [7:0] mem_data = 8'd0;
  logic       buf_valid;
  logic       buf_ready = 1'b1;
  logic [7:0] buf_data;
  logic       stall;
  logic       irq;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int lat = 0, wcnt = 0, fetch_cnt = 0;
  int seen[$];
  bit done = 0;

  // reference model state
  int m_addr = 'hC000, m_rem = 0, m_data = 0;
  bit m_busy = 0, m_full = 0, m_irq = 0, m_irqen = 0, m_loop = 0, m_enq = 0;
  int m_acode = 0, m_lcode = 0;

  smp_fetch_ctl u0 (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_data(mem_data), .buf_valid(buf_valid), .buf_ready(buf_ready),
    .buf_data(buf_data), .stall(stall), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_addr = 'hC000; m_rem = 0; m_data = 0; m_busy = 0; m_full = 0;
      m_irq = 0; m_irqen = 0; m_loop = 0; m_enq = 0; m_acode = 0; m_lcode = 0;
    end else begin
      bit fire, start_f, take, load, is_last, irq_set, irq_clr;
      int start_a, len_b;
      fire    = m_busy && mem_ack;
      start_f = !m_busy && !m_full && m_rem != 0 && chan_en;
      take    = m_full && buf_ready;
      load    = chan_en && !m_enq && m_rem == 0;
      is_last = m_rem == 1;
      start_a = 'hC000 + m_acode * 64;
      len_b   = m_lcode * 16 + 1;
      irq_set = fire && is_last && !m_loop && m_irqen;
      irq_clr = wr_en && wr_sel == 2'd0 && !wr_data[7];
      if (fire) m_addr = (m_addr == 'hFFFF) ? 'h8000 : m_addr + 1;
      if (!chan_en) m_rem = 0;
      else if (load) begin m_addr = start_a; m_rem = len_b; end
      else if (fire && m_rem != 0) begin
        if (is_last && m_loop) begin m_addr = start_a; m_rem = len_b; end
        else m_rem = m_rem - 1;
      end
      if (irq_clr) m_irq = 0; else if (irq_set) m_irq = 1;
      if (fire) begin m_busy = 0; m_full = 1; m_data = mem_data; end
      else begin
        if (start_f) m_busy = 1;
        if (take) m_full = 0;
      end
      m_enq = chan_en;
      if (wr_en) begin
        case (wr_sel)
          2'd0: begin m_irqen = wr_data[7]; m_loop = wr_data[6]; end
          2'd1: m_acode = wr_data;
          2'd2: m_lcode = wr_data;
          default: ;
        endcase
      end
    end
  end

  // per-cycle compare and memory responder
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(mem_req == m_busy, "R5", "mem_req", mem_req, m_busy);
      chk(mem_addr == m_addr[15:0], "R7", "mem_addr", mem_addr, m_addr);
      chk(stall == m_busy, "R6", "stall", stall, m_busy);
      chk(buf_valid == m_full, "R11", "buf_valid", buf_valid, m_full);
      chk(buf_data == m_data[7:0], "R11", "buf_data", buf_data, m_data);
      chk(irq == m_irq, "R9", "irq", irq, m_irq);
    end
    if (mem_req && wcnt >= lat) begin
      mem_ack  <= 1'b1;
      mem_data <= mem_byte(mem_addr);
      seen.push_back(int'(mem_addr));
      fetch_cnt++;
      wcnt = 0;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req) wcnt++;
    end
    if (cyc > WATCHDOG && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_sel = 2'd3;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int base_cnt;
    idle(3);
    // R12 reset state
    chk(!mem_req && !stall, "R12", "req/stall in reset", {mem_req, stall}, 0);
    chk(!irq && !buf_valid, "R12", "irq/buf in reset", {irq, buf_valid}, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    chk(!mem_req && !irq && !buf_valid, "R12", "after reset",
        {mem_req, irq, buf_valid}, 0);

    // one-byte sample with interrupt enabled
    wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd0, 8'h80);
    lat = 0; buf_ready = 1'b1; seen.delete(); fetch_cnt = 0;
    chan_en = 1'b1;
    @(negedge clk);
    chk(!mem_req, "R4", "req one edge after start", mem_req, 0);
    @(negedge clk);
    chk(mem_req, "R4", "req two edges after start", mem_req, 1);
    chk(mem_addr == 16'hC000, "R1", "start address code 0", mem_addr, 'hC000);
    idle(10);
    chk(fetch_cnt == 1, "R2", "length code 0 gives one byte", fetch_cnt, 1);
    chk(irq, "R9", "irq after last byte", irq, 1);

    // control write with bit 7 clear, low bits set
    wr(2'd0, 8'h0F);
    chk(!irq, "R3", "irq cleared by control write", irq, 0);
    wr(2'd3, 8'hFF);
    idle(5);
    chk(fetch_cnt == 1, "R3", "ignored bits start nothing", fetch_cnt, 1);

    // 65-byte sample crossing the top of memory
    @(negedge clk); chan_en = 1'b0;
    wr(2'd1, 8'hFF); wr(2'd2, 8'h04); wr(2'd0, 8'h00);
    lat = 1; seen.delete(); fetch_cnt = 0;
    @(negedge clk); chan_en = 1'b1;
    idle(600);
    chk(fetch_cnt == 65, "R2", "length code 4 byte count", fetch_cnt, 65);
    chk(seen.size() == 65 && seen[0] == 'hFFC0, "R1", "start address code FF",
        seen.size() > 0 ? seen[0] : -1, 'hFFC0);
    chk(seen.size() == 65 && seen[63] == 'hFFFF, "R7", "byte 64 at top",
        seen.size() > 63 ? seen[63] : -1, 'hFFFF);
    chk(seen.size() == 65 && seen[64] == 'h8000, "R7", "wrap to 8000",
        seen.size() > 64 ? seen[64] : -1, 'h8000);
    chk(!irq, "R9", "no irq with interrupt disabled", irq, 0);

    // looping one-byte sample with back-pressure
    @(negedge clk); chan_en = 1'b0;
    wr(2'd1, 8'h10); wr(2'd2, 8'h00); wr(2'd0, 8'hC0);
    lat = 0; seen.delete(); fetch_cnt = 0; buf_ready = 1'b0;
    @(negedge clk); chan_en = 1'b1;
    idle(12);
    chk(fetch_cnt == 1, "R11", "no fetch while buffer full", fetch_cnt, 1);
    chk(buf_valid && buf_data == mem_byte(16'hC400), "R11", "held byte",
        buf_data, mem_byte(16'hC400));
    buf_ready = 1'b1;
    idle(20);
    chk(fetch_cnt >= 4, "R8", "loop keeps fetching", fetch_cnt, 4);
    begin
      bit all_same = 1;
      foreach (seen[i]) if (seen[i] != 'hC400) all_same = 0;
      chk(all_same, "R8", "loop reloads start address", seen[seen.size()-1], 'hC400);
    end
    chk(!irq, "R9", "no irq while looping", irq, 0);

    // disable while a fetch is outstanding
    lat = 4;
    for (int i = 0; i < 50 && !mem_req; i++) @(negedge clk);
    chk(mem_req, "R10", "fetch outstanding before disable", mem_req, 1);
    base_cnt = fetch_cnt;
    chan_en = 1'b0;
    idle(30);
    chk(fetch_cnt == base_cnt + 1, "R10", "outstanding fetch completes",
        fetch_cnt, base_cnt + 1);
    chk(!mem_req && !stall, "R10", "no new fetch when disabled", mem_req, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule